// File: doc/BRIEF.md
# Board Interrupt Aggregator with Detection Registers

This block is the register side of a board-control logic device that sits next to a host processor. Up to sixteen peripheral interrupt wires come in asynchronously. Each passes through a synchronizer, and its rising edge latches a sticky status bit. The host sees one active-low, level-type interrupt line. The line is driven low while any latched bit is not masked. Software reads the status word and masks lines one by one. It releases a latched bit by pulsing the matching bit of a separate clear register: it writes a 1, then a 0.

The same 16-bit synchronous bus also serves the board-detection words and a code version word. It also serves a few plain storage registers and a synchronized view of the board push-buttons. The detection words are three fixed constants, and software compares them before it trusts the board.

The host line is produced by a two-state machine. IRQ_IDLE drives the line high. It takes the transition IDLE_TO_ACTIVE when any unmasked status bit is set. IRQ_ACTIVE drives the line low. It takes the transition ACTIVE_TO_IDLE once no unmasked status bit remains. Otherwise each state holds.

Top module: `brd_irq_hub`

## Requirements
- R1: After reset the mask word (offset 0x38) reads 0xFFFF, the status word (0x10) and the clear word (0x20) read 0x0000, and `irq_n` is high.
- R2: Interrupt source k sets status bit k on a rising edge of `src_in[k]`, which is first passed through a two-flop synchronizer. The bit stays set after the source falls. Bit 0 is the Ethernet controller, bit 1 serial port A, bit 2 serial port B, bit 3 button A and bit 4 button B.
- R3: While clear bit k (offset 0x20) is 1, status bit k is forced to 0, and this wins over a new rising edge. Writing 0 back releases it. Writing 0xFFFF clears every status bit.
- R4: `irq_n` goes low one clock after some status bit is 1 with its mask bit 0. It goes high one clock after no such bit remains.
- R5: A mask bit of 1 keeps its line from driving `irq_n`, but the status bit is still recorded. The mask word is read/write at 0x38.
- R6: Offset 0x40 reads 0xAAAA, 0x48 reads 0x5555, 0x58 reads 0xCAFE and 0x50 reads the code-version parameter (default 0x0107).
- R7: Offsets 0x00, 0x60 and 0x68 are 16-bit read/write storage. Offset 0x08 reads the two-flop synchronized `btn_in` in its low bits.
- R8: A read of an unmapped offset returns 0x0000. A write to an unmapped offset or to a read-only offset (status, ID, version, buttons) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC (16) | Asynchronous interrupt source wires |
| btn_in | input | BTN_W (2) | Asynchronous push-button levels |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the read strobe |
| irq_n | output | 1 | Active-low level interrupt to the host |

## Verification
The bench builds the block with its default parameters: sixteen source lines, two buttons and version word 0x0107. With sixteen lines the top status bit 15 shares the full data width with no padding, so the highest line can be checked together with the low lines. The bench also covers the zero-fill path of the button word. Keeping the synchronizer at two stages fixes the source-to-status delay at three clocks, which the directed tests rely on when they place an edge while a clear bit is held.

// File: rtl/brd_pkg.sv
package brd_pkg;
    localparam int BUS_AW = 8;
    localparam int BUS_DW = 16;

    localparam logic [BUS_AW-1:0] OFS_LEDSW  = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_BTN    = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_STAT   = 8'h10;
    localparam logic [BUS_AW-1:0] OFS_CLR    = 8'h20;
    localparam logic [BUS_AW-1:0] OFS_MASK   = 8'h38;
    localparam logic [BUS_AW-1:0] OFS_ID_A   = 8'h40;
    localparam logic [BUS_AW-1:0] OFS_ID_B   = 8'h48;
    localparam logic [BUS_AW-1:0] OFS_VER    = 8'h50;
    localparam logic [BUS_AW-1:0] OFS_ID_C   = 8'h58;
    localparam logic [BUS_AW-1:0] OFS_MODRST = 8'h60;
    localparam logic [BUS_AW-1:0] OFS_BRDID  = 8'h68;

    localparam logic [BUS_DW-1:0] ID_WORD_A = 16'hAAAA;
    localparam logic [BUS_DW-1:0] ID_WORD_B = 16'h5555;
    localparam logic [BUS_DW-1:0] ID_WORD_C = 16'hCAFE;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_t;
endpackage

// File: rtl/brd_src_sync.sv
module brd_src_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise
);
    localparam int CHAIN = STAGES + 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic [CHAIN-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[CHAIN-2:0], async_in[i]};
            end
        end

        assign rise[i] = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
    end
endmodule

// File: rtl/brd_irq_core.sv
module brd_irq_core
    import brd_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise,
    input  logic               mask_we,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] status_q,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] clr_q,
    output logic               irq_n
);
    irq_state_t state_q, state_d;
    logic       any_pending;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            clr_q  <= '0;
        end else begin
            if (mask_we) mask_q <= wdata;
            if (clr_we)  clr_q  <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q | rise) & ~clr_q;
        end
    end

    assign any_pending = |(status_q & ~mask_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (any_pending)  state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!any_pending) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_n = 1'b1;
        unique case (state_q)
            IRQ_IDLE:   irq_n = 1'b1;
            IRQ_ACTIVE: irq_n = 1'b0;
            default:    irq_n = 1'b1;
        endcase
    end

    assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_q != '0) |=> ((status_q & $past(clr_q)) == '0));

    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise & ~clr_q) != '0) |=>
            ((status_q & $past(rise & ~clr_q)) == $past(rise & ~clr_q)));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~clr_q) != '0) |=>
            ((status_q & $past(status_q & ~clr_q)) == $past(status_q & ~clr_q)));

    assert_irq_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~mask_q) != '0) |=> !irq_n);

    assert_irq_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~mask_q) == '0) |=> irq_n);
endmodule

// File: rtl/brd_regs.sv
module brd_regs
    import brd_pkg::*;
#(
    parameter int                NUM_SRC  = 16,
    parameter int                BTN_W    = 2,
    parameter logic [BUS_DW-1:0] CODE_VER = 16'h0107
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BTN_W-1:0]   btn_in,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [BUS_DW-1:0]  bus_wdata,
    output logic [BUS_DW-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] status_q,
    input  logic [NUM_SRC-1:0] mask_q,
    input  logic [NUM_SRC-1:0] clr_q,
    output logic               mask_we,
    output logic               clr_we
);
    logic [BUS_DW-1:0] ledsw_q, modrst_q, brdid_q;
    logic [BTN_W-1:0]  btn_s1, btn_s2;
    logic              wr_en;
    logic [BUS_DW-1:0] stat_w, mask_w, clr_w, btn_w, rd_mux;

    assign wr_en   = bus_sel & bus_wr;
    assign mask_we = wr_en & (bus_addr == OFS_MASK);
    assign clr_we  = wr_en & (bus_addr == OFS_CLR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ledsw_q  <= '0;
            modrst_q <= '0;
            brdid_q  <= '0;
        end else if (wr_en) begin
            unique case (bus_addr)
                OFS_LEDSW:  ledsw_q  <= bus_wdata;
                OFS_MODRST: modrst_q <= bus_wdata;
                OFS_BRDID:  brdid_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            btn_s1 <= '0;
            btn_s2 <= '0;
        end else begin
            btn_s1 <= btn_in;
            btn_s2 <= btn_s1;
        end
    end

    always_comb begin
        stat_w = '0;
        mask_w = '0;
        clr_w  = '0;
        btn_w  = '0;
        stat_w[NUM_SRC-1:0] = status_q;
        mask_w[NUM_SRC-1:0] = mask_q;
        clr_w[NUM_SRC-1:0]  = clr_q;
        btn_w[BTN_W-1:0]    = btn_s2;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_LEDSW:  rd_mux = ledsw_q;
            OFS_BTN:    rd_mux = btn_w;
            OFS_STAT:   rd_mux = stat_w;
            OFS_CLR:    rd_mux = clr_w;
            OFS_MASK:   rd_mux = mask_w;
            OFS_ID_A:   rd_mux = ID_WORD_A;
            OFS_ID_B:   rd_mux = ID_WORD_B;
            OFS_VER:    rd_mux = CODE_VER;
            OFS_ID_C:   rd_mux = ID_WORD_C;
            OFS_MODRST: rd_mux = modrst_q;
            OFS_BRDID:  rd_mux = brdid_q;
            default:    rd_mux = '0;
        endcase
    end

    assign bus_rdata = (bus_sel && !bus_wr) ? rd_mux : '0;

    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mask_we && clr_we));
endmodule

// File: rtl/brd_irq_hub.sv
module brd_irq_hub
    import brd_pkg::*;
#(
    parameter int                NUM_SRC     = 16,
    parameter int                BTN_W       = 2,
    parameter int                SYNC_STAGES = 2,
    parameter logic [BUS_DW-1:0] CODE_VER    = 16'h0107
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [BTN_W-1:0]   btn_in,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [BUS_DW-1:0]  bus_wdata,
    output logic [BUS_DW-1:0]  bus_rdata,
    output logic               irq_n
);
    logic [NUM_SRC-1:0] rise, status_q, mask_q, clr_q;
    logic               mask_we, clr_we;

    brd_src_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(src_in), .rise(rise)
    );

    brd_irq_core #(.NUM_SRC(NUM_SRC)) u_core (
        .clk(clk), .rst_n(rst_n), .rise(rise),
        .mask_we(mask_we), .clr_we(clr_we), .wdata(bus_wdata[NUM_SRC-1:0]),
        .status_q(status_q), .mask_q(mask_q), .clr_q(clr_q), .irq_n(irq_n)
    );

    brd_regs #(.NUM_SRC(NUM_SRC), .BTN_W(BTN_W), .CODE_VER(CODE_VER)) u_regs (
        .clk(clk), .rst_n(rst_n), .btn_in(btn_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .status_q(status_q), .mask_q(mask_q), .clr_q(clr_q),
        .mask_we(mask_we), .clr_we(clr_we)
    );
endmodule

// File: tb/brd_irq_hub_test.sv
module brd_irq_hub_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_in = '0;
    logic [1:0]  btn_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_n;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    brd_irq_hub uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .btn_in(btn_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    // {write, offset, data, expected read}
    localparam int NV = 22;
    localparam logic [40:0] VEC [NV] = '{
        {1'b0, 8'h40, 16'h0000, 16'hAAAA},   // R6
        {1'b0, 8'h48, 16'h0000, 16'h5555},   // R6
        {1'b0, 8'h58, 16'h0000, 16'hCAFE},   // R6
        {1'b0, 8'h50, 16'h0000, 16'h0107},   // R6
        {1'b1, 8'h00, 16'hA5C3, 16'h0000},   // R7
        {1'b0, 8'h00, 16'h0000, 16'hA5C3},   // R7
        {1'b1, 8'h60, 16'h0F0F, 16'h0000},   // R7
        {1'b0, 8'h60, 16'h0000, 16'h0F0F},   // R7
        {1'b1, 8'h68, 16'h1357, 16'h0000},   // R7
        {1'b0, 8'h68, 16'h0000, 16'h1357},   // R7
        {1'b1, 8'h40, 16'h0000, 16'h0000},   // R8
        {1'b0, 8'h40, 16'h0000, 16'hAAAA},   // R8
        {1'b0, 8'h30, 16'h0000, 16'h0000},   // R8
        {1'b1, 8'h30, 16'hFFFF, 16'h0000},   // R8
        {1'b0, 8'h30, 16'h0000, 16'h0000},   // R8
        {1'b1, 8'h38, 16'h00F0, 16'h0000},   // R5
        {1'b0, 8'h38, 16'h0000, 16'h00F0},   // R5
        {1'b1, 8'h10, 16'hFFFF, 16'h0000},   // R8
        {1'b0, 8'h10, 16'h0000, 16'h0000},   // R8
        {1'b1, 8'h38, 16'hFFFF, 16'h0000},   // R5
        {1'b0, 8'h38, 16'h0000, 16'hFFFF},   // R5
        {1'b0, 8'h08, 16'h0000, 16'h0000}    // R7
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got 0x0000 expected 0x0001");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 irq_n", {15'd0, irq_n}, 16'h0001);
        bus_read(8'h38, rd); check("R1 mask", rd, 16'hFFFF);
        bus_read(8'h10, rd); check("R1 status", rd, 16'h0000);
        bus_read(8'h20, rd); check("R1 clear", rd, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][40]) begin
                bus_write(VEC[i][39:32], VEC[i][31:16]);
            end else begin
                bus_read(VEC[i][39:32], rd);
                check($sformatf("table[%0d] R5/R6/R7/R8", i), rd, VEC[i][15:0]);
            end
        end
        check("R5 irq idle after table", {15'd0, irq_n}, 16'h0001);

        // R2 edge on Ethernet line, masked: status set, line quiet (R5)
        src_in[0] = 1'b1; idle(5);
        bus_read(8'h10, rd); check("R2 set bit0", rd, 16'h0001);
        check("R5 masked no irq", {15'd0, irq_n}, 16'h0001);

        // R4 unmask -> line low one clock later
        bus_write(8'h38, 16'hFFFE);
        check("R4 not yet", {15'd0, irq_n}, 16'h0001);
        idle(1);
        check("R4 irq low", {15'd0, irq_n}, 16'h0000);

        // R2 sticky after source falls
        src_in[0] = 1'b0; idle(5);
        bus_read(8'h10, rd); check("R2 sticky", rd, 16'h0001);

        // R3 clear pulse, first half
        bus_write(8'h20, 16'h0001);
        idle(1);
        bus_read(8'h10, rd); check("R3 cleared", rd, 16'h0000);
        check("R4 irq high", {15'd0, irq_n}, 16'h0001);

        // R3 clear held wins over new edge
        src_in[0] = 1'b1; idle(5);
        bus_read(8'h10, rd); check("R3 clear wins", rd, 16'h0000);
        check("R3 irq quiet", {15'd0, irq_n}, 16'h0001);
        bus_write(8'h20, 16'h0000); idle(4);
        bus_read(8'h10, rd); check("R3 no edge after release", rd, 16'h0000);
        src_in[0] = 1'b0; idle(4);
        src_in[0] = 1'b1; idle(5);
        bus_read(8'h10, rd); check("R3 set after release", rd, 16'h0001);

        // R5 lines 4 and 15 masked, line 0 unmasked
        src_in[15] = 1'b1; src_in[4] = 1'b1; idle(5);
        bus_read(8'h10, rd); check("R2 bits 15,4,0", rd, 16'h8011);
        check("R4 irq low", {15'd0, irq_n}, 16'h0000);
        bus_write(8'h20, 16'h0001); bus_write(8'h20, 16'h0000); idle(3);
        bus_read(8'h10, rd); check("R5 masked bits remain", rd, 16'h8010);
        check("R5 masked bits no irq", {15'd0, irq_n}, 16'h0001);

        // R4 unmask line 4
        bus_write(8'h38, 16'hFFEE); idle(2);
        check("R4 irq from bit4", {15'd0, irq_n}, 16'h0000);

        // R3 clear everything
        bus_write(8'h20, 16'hFFFF); bus_write(8'h20, 16'h0000); idle(3);
        bus_read(8'h10, rd); check("R3 clear all", rd, 16'h0000);
        check("R4 irq released", {15'd0, irq_n}, 16'h0001);

        // R7 buttons through synchronizer
        btn_in = 2'b10; idle(4);
        bus_read(8'h08, rd); check("R7 buttons", rd, 16'h0002);
        bus_write(8'h08, 16'hFFFF);
        bus_read(8'h08, rd); check("R8 button write ignored", rd, 16'h0002);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule